// File: doc/BRIEF.md
# Bus Slave Address and Register-Strobe Decoder

This block is the slave-side front end of a 16-channel I/O card on an asynchronous backplane bus. It watches the address, the six-bit address modifier, the address strobe, the two data strobes and the write line. It decides whether a cycle belongs to this card and which of its 16-bit registers is addressed. A hit produces a one-cycle read or write strobe toward the channel logic that owns the registers. It also drives read data onto the bus and returns the data-transfer acknowledge (DTACK, active low). The card's base address comes from static switch inputs and always falls on a 64 KB page.

The decoder accepts 24-bit and 32-bit addressing. Both forms reach the same 24-slot map, with one slot every two bytes. Each slot can be read, written, both, or neither. An access the slot does not allow still gets an acknowledge, so the bus master never times out. Such a write leaves every register untouched and such a read returns zero. Read-clear slots get an ordinary read strobe, and the channel logic clears its flip-flops when it sees it. All bus inputs are assumed to be synchronous to `clk`.

Top module: `vbus_reg_decoder`

## Requirements
- R1: Only address-modifier codes 0x39 and 0x3D (24-bit space) and 0x09 and 0x0D (32-bit space) are answered. Any other code gets no DTACK and no strobe.
- R2: In 24-bit space, address bits 23..16 must equal switch bits 7..0, and address bits 31..24 are ignored. In 32-bit space, address bits 31..16 must equal switch bits 15..0.
- R3: Address bits 15..6 must be zero for a hit. Byte offsets 0x30..0x3E are outside the map and get no DTACK.
- R4: A cycle is taken only while the address strobe and both data strobes are low (16-bit transfer). With only one data strobe low, the cycle is not answered.
- R5: Let E0 be the first rising edge that sees the strobes active on a hit. DTACK goes low after edge E0+1 and stays low while either data strobe is low. It goes high after the first edge that sees both data strobes high. If the strobes are dropped before E0+1, the cycle is not acknowledged.
- R6: A read of a readable slot pulses bit offset/2 of `reg_rd_o` for exactly the cycle in which DTACK falls. `vme_data_o` holds slice [16*(offset/2) +: 16] of `reg_rdata_i` as taken at that edge. `vme_data_oe_o` is high exactly while DTACK is low for a read, and `vme_data_o` returns to zero on release.
- R7: A write to a writable slot pulses bit offset/2 of `reg_wr_o` for exactly the cycle in which DTACK falls. `reg_wdata_o` then carries the data lines as sampled at edge E0.
- R8: Readable offsets are 0x00..0x0E, 0x16, 0x18, 0x1A and 0x20..0x2A. Writable offsets are 0x00, 0x02, 0x0A, 0x0C, 0x0E, 0x10, 0x1A, 0x20, 0x22, 0x28, 0x2A and 0x2E.
- R9: These accesses are still acknowledged: any access to the reserved offsets 0x12, 0x14, 0x1C, 0x1E and 0x2C, a write to a read-only offset, and a read of a write-only offset (0x10, 0x2E). They raise no strobe, and a read of this kind returns zero.
- R10: One strobe assertion yields exactly one register strobe however long it is held. At most one strobe bit is high in any cycle. A new access is decoded when the data strobes go high for a single cycle and then low again.
- R11: After reset DTACK is high, the output enable is low, all strobes are zero and `vme_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| vme_addr_i | input | 31 | Address lines A31..A1 |
| vme_am_i | input | 6 | Address modifier |
| vme_as_n_i | input | 1 | Address strobe, active low |
| vme_ds0_n_i | input | 1 | Data strobe 0, active low |
| vme_ds1_n_i | input | 1 | Data strobe 1, active low |
| vme_write_n_i | input | 1 | Low for a write cycle |
| vme_data_i | input | 16 | Write data from the bus |
| base_sw_i | input | 16 | Base page switches (A31..A16) |
| reg_rdata_i | input | 384 | Current values of all 24 slots, slot n at [16n +: 16] |
| vme_data_o | output | 16 | Read data to the bus |
| vme_data_oe_o | output | 1 | Drive enable for read data |
| vme_dtack_n_o | output | 1 | Data-transfer acknowledge, active low |
| reg_rd_o | output | 24 | One-cycle read strobe per slot |
| reg_wr_o | output | 24 | One-cycle write strobe per slot |
| reg_wdata_o | output | 16 | Write data for the strobed slot |

## Verification
The end of one bus cycle and the start of the next can meet in adjacent cycles. The release of DTACK for the old cycle is then followed straight away by the decode of the new one. The bench forces this by raising the data strobes for a single clock and lowering them again at once with a new address and direction. It expects two separate acknowledges, each with its own single strobe for the right slot. The behavioural reference model judges every cycle of that sequence, so a lost or merged second access shows up as a mismatch in the exact cycle where it happens.

// File: rtl/vbd_pkg.sv
package vbd_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 32;
    localparam int SW_W      = 16;
    localparam int AM_W      = 6;
    localparam int NUM_REGS  = 24;
    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int PAGE_LSB  = 16;
    localparam int A24_MSB   = 23;
    localparam int IDX_LSB   = 1;
    localparam int MID_LSB   = IDX_LSB + IDX_W;
    localparam int MID_MSB   = PAGE_LSB - 1;
    localparam int A24_PAGE_W = A24_MSB - PAGE_LSB + 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DECODE = 2'd1,
        PH_ACK    = 2'd2,
        PH_SKIP   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SP_NONE = 2'd0,
        SP_A24  = 2'd1,
        SP_A32  = 2'd2
    } space_e;

    typedef struct packed {
        logic readable;
        logic writable;
    } reg_attr_t;

    typedef struct packed {
        logic              is_write;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] wdata;
    } req_t;

    function automatic space_e am_space(input logic [AM_W-1:0] am);
        case (am)
            6'h39, 6'h3D: return SP_A24;
            6'h09, 6'h0D: return SP_A32;
            default:      return SP_NONE;
        endcase
    endfunction

    function automatic reg_attr_t reg_attr(input logic [IDX_W-1:0] idx);
        reg_attr_t a;
        a = '{readable: 1'b0, writable: 1'b0};
        case (idx)
            5'd0, 5'd1, 5'd5, 5'd6, 5'd7,
            5'd13, 5'd16, 5'd17, 5'd20, 5'd21: a = '{readable: 1'b1, writable: 1'b1};
            5'd2, 5'd3, 5'd4, 5'd11, 5'd12,
            5'd18, 5'd19:                       a = '{readable: 1'b1, writable: 1'b0};
            5'd8, 5'd23:                        a = '{readable: 1'b0, writable: 1'b1};
            default:                            a = '{readable: 1'b0, writable: 1'b0};
        endcase
        return a;
    endfunction

    function automatic logic [NUM_REGS-1:0] writable_mask();
        logic [NUM_REGS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REGS; i++) m[i] = reg_attr(IDX_W'(i)).writable;
        return m;
    endfunction

    function automatic logic [NUM_REGS-1:0] readable_mask();
        logic [NUM_REGS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_REGS; i++) m[i] = reg_attr(IDX_W'(i)).readable;
        return m;
    endfunction

endpackage

// File: rtl/vbd_addr_match.sv
module vbd_addr_match
    import vbd_pkg::*;
#(
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SW_W   = SW_W,
    parameter int P_NREGS  = NUM_REGS
) (
    input  logic [P_ADDR_W-1:1] addr,
    input  logic [AM_W-1:0]     am,
    input  logic [P_SW_W-1:0]   base_sw,
    output logic                hit,
    output logic [IDX_W-1:0]    idx
);

    space_e space;
    logic   page_ok;
    logic   mid_zero;
    logic   in_map;

    always_comb begin
        space    = am_space(am);
        idx      = addr[MID_LSB-1:IDX_LSB];
        mid_zero = (addr[MID_MSB:MID_LSB] == '0);
        in_map   = (32'(idx) < 32'(P_NREGS));
        case (space)
            SP_A24:  page_ok = (addr[A24_MSB:PAGE_LSB] == base_sw[A24_PAGE_W-1:0]);
            SP_A32:  page_ok = (addr[P_ADDR_W-1:PAGE_LSB] == base_sw);
            default: page_ok = 1'b0;
        endcase
        hit = page_ok & mid_zero & in_map;
    end

endmodule

// File: rtl/vbd_rdata_mux.sv
module vbd_rdata_mux
    import vbd_pkg::*;
#(
    parameter int P_NREGS  = NUM_REGS,
    parameter int P_DATA_W = DATA_W
) (
    input  logic [IDX_W-1:0]            idx,
    input  logic [P_NREGS*P_DATA_W-1:0] rdata_flat,
    output logic [P_DATA_W-1:0]         rdata
);

    logic [P_DATA_W-1:0] slots [P_NREGS];

    for (genvar g = 0; g < P_NREGS; g++) begin : g_slot
        assign slots[g] = rdata_flat[g*P_DATA_W +: P_DATA_W];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < P_NREGS; i++) begin
            if (idx == IDX_W'(i) && reg_attr(IDX_W'(i)).readable) rdata = slots[i];
        end
    end

endmodule

// File: rtl/vbd_cycle_ctrl.sv
module vbd_cycle_ctrl
    import vbd_pkg::*;
#(
    parameter int P_NREGS  = NUM_REGS,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                strobe_act,
    input  logic                ds_idle,
    input  logic                hit,
    input  logic                is_write,
    input  logic [IDX_W-1:0]    idx_in,
    input  logic [P_DATA_W-1:0] wdata_in,
    input  logic [P_DATA_W-1:0] rdata_sel,
    output logic [IDX_W-1:0]    cur_idx,
    output logic                dtack_n,
    output logic [P_NREGS-1:0]  rd_stb,
    output logic [P_NREGS-1:0]  wr_stb,
    output logic [P_DATA_W-1:0] data_out,
    output logic                data_oe,
    output logic [P_DATA_W-1:0] wdata_out
);

    phase_e              ph_q;
    req_t                req_q;
    reg_attr_t           attr;
    logic [P_NREGS-1:0]  sel_onehot;

    always_comb begin
        attr       = reg_attr(req_q.idx);
        sel_onehot = P_NREGS'(1) << req_q.idx;
        cur_idx    = req_q.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q      <= PH_IDLE;
            req_q     <= '0;
            dtack_n   <= 1'b1;
            rd_stb    <= '0;
            wr_stb    <= '0;
            data_out  <= '0;
            data_oe   <= 1'b0;
            wdata_out <= '0;
        end else begin
            rd_stb <= '0;
            wr_stb <= '0;
            case (ph_q)
                PH_IDLE: begin
                    if (strobe_act) begin
                        if (hit) begin
                            req_q <= '{is_write: is_write, idx: idx_in, wdata: wdata_in};
                            ph_q  <= PH_DECODE;
                        end else begin
                            ph_q  <= PH_SKIP;
                        end
                    end
                end
                PH_DECODE: begin
                    if (strobe_act) begin
                        ph_q      <= PH_ACK;
                        dtack_n   <= 1'b0;
                        wdata_out <= req_q.wdata;
                        if (req_q.is_write) begin
                            data_out <= '0;
                            data_oe  <= 1'b0;
                            if (attr.writable) wr_stb <= sel_onehot;
                        end else begin
                            data_out <= rdata_sel;
                            data_oe  <= 1'b1;
                            if (attr.readable) rd_stb <= sel_onehot;
                        end
                    end else begin
                        ph_q <= PH_IDLE;
                    end
                end
                PH_ACK: begin
                    if (ds_idle) begin
                        ph_q     <= PH_IDLE;
                        dtack_n  <= 1'b1;
                        data_oe  <= 1'b0;
                        data_out <= '0;
                    end
                end
                PH_SKIP: begin
                    if (ds_idle) ph_q <= PH_IDLE;
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vbus_reg_decoder.sv
module vbus_reg_decoder
    import vbd_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:1]            vme_addr_i,
    input  logic [AM_W-1:0]              vme_am_i,
    input  logic                         vme_as_n_i,
    input  logic                         vme_ds0_n_i,
    input  logic                         vme_ds1_n_i,
    input  logic                         vme_write_n_i,
    input  logic [DATA_W-1:0]            vme_data_i,
    input  logic [SW_W-1:0]              base_sw_i,
    input  logic [NUM_REGS*DATA_W-1:0]   reg_rdata_i,
    output logic [DATA_W-1:0]            vme_data_o,
    output logic                         vme_data_oe_o,
    output logic                         vme_dtack_n_o,
    output logic [NUM_REGS-1:0]          reg_rd_o,
    output logic [NUM_REGS-1:0]          reg_wr_o,
    output logic [DATA_W-1:0]            reg_wdata_o
);

    logic              strobe_act;
    logic              ds_idle;
    logic              hit;
    logic [IDX_W-1:0]  dec_idx;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] rdata_sel;

    assign strobe_act = ~vme_as_n_i & ~vme_ds0_n_i & ~vme_ds1_n_i;
    assign ds_idle    = vme_ds0_n_i & vme_ds1_n_i;

    vbd_addr_match #(
        .P_ADDR_W (ADDR_W),
        .P_SW_W   (SW_W),
        .P_NREGS  (NUM_REGS)
    ) u_match (
        .addr    (vme_addr_i),
        .am      (vme_am_i),
        .base_sw (base_sw_i),
        .hit     (hit),
        .idx     (dec_idx)
    );

    vbd_rdata_mux #(
        .P_NREGS  (NUM_REGS),
        .P_DATA_W (DATA_W)
    ) u_mux (
        .idx        (cur_idx),
        .rdata_flat (reg_rdata_i),
        .rdata      (rdata_sel)
    );

    vbd_cycle_ctrl #(
        .P_NREGS  (NUM_REGS),
        .P_DATA_W (DATA_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .strobe_act (strobe_act),
        .ds_idle    (ds_idle),
        .hit        (hit),
        .is_write   (~vme_write_n_i),
        .idx_in     (dec_idx),
        .wdata_in   (vme_data_i),
        .rdata_sel  (rdata_sel),
        .cur_idx    (cur_idx),
        .dtack_n    (vme_dtack_n_o),
        .rd_stb     (reg_rd_o),
        .wr_stb     (reg_wr_o),
        .data_out   (vme_data_o),
        .data_oe    (vme_data_oe_o),
        .wdata_out  (reg_wdata_o)
    );

endmodule

// File: rtl/vbd_checker.sv
module vbd_checker
    import vbd_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [AM_W-1:0]     am,
    input logic                as_n,
    input logic                ds0_n,
    input logic                ds1_n,
    input logic                dtack_n,
    input logic                data_oe,
    input logic [NUM_REGS-1:0] rd,
    input logic [NUM_REGS-1:0] wr
);

    localparam logic [NUM_REGS-1:0] WMASK = writable_mask();
    localparam logic [NUM_REGS-1:0] RMASK = readable_mask();

    AST_AM_FILTER: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> $past(am_space(am) != SP_NONE, 2)); // R1

    AST_DTACK_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
        $fell(dtack_n) |-> $past(!as_n && !ds0_n && !ds1_n)); // R4

    AST_DTACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        ($past(!dtack_n) && $past(ds0_n && ds1_n)) |-> dtack_n); // R5

    AST_STROBE_ON_ACK_EDGE: assert property (@(posedge clk) disable iff (rst)
        ((|rd) || (|wr)) |-> (!dtack_n && $past(dtack_n))); // R6

    AST_OE_WITHIN_ACK: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !dtack_n); // R6

    AST_WR_ONLY_WRITABLE: assert property (@(posedge clk) disable iff (rst)
        (wr & ~WMASK) == '0); // R8

    AST_RD_ONLY_READABLE: assert property (@(posedge clk) disable iff (rst)
        (rd & ~RMASK) == '0); // R8

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd, wr})); // R10

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dtack_n && !data_oe)); // R11

endmodule

bind vbus_reg_decoder vbd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .am      (vme_am_i),
    .as_n    (vme_as_n_i),
    .ds0_n   (vme_ds0_n_i),
    .ds1_n   (vme_ds1_n_i),
    .dtack_n (vme_dtack_n_o),
    .data_oe (vme_data_oe_o),
    .rd      (reg_rd_o),
    .wr      (reg_wr_o)
);

// File: tb/vbus_reg_decoder_tb.sv
module vbus_reg_decoder_tb;

    localparam int NR = 24;
    localparam logic [15:0] BASE = 16'h12AB;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic [5:0]  am = '0;
    logic        as_n = 1'b1, ds0_n = 1'b1, ds1_n = 1'b1, write_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [NR*16-1:0] rflat;
    logic [15:0] pat [NR];
    logic [15:0] data_o, wdata_o;
    logic        oe, dtack_n;
    logic [NR-1:0] rd, wr;

    int n_checks = 0, n_err = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NR; i++) rflat[i*16 +: 16] = pat[i];
    end

    vbus_reg_decoder u_dut (
        .clk(clk), .rst(rst), .vme_addr_i(addr[31:1]), .vme_am_i(am),
        .vme_as_n_i(as_n), .vme_ds0_n_i(ds0_n), .vme_ds1_n_i(ds1_n),
        .vme_write_n_i(write_n), .vme_data_i(wdata), .base_sw_i(BASE),
        .reg_rdata_i(rflat), .vme_data_o(data_o), .vme_data_oe_o(oe),
        .vme_dtack_n_o(dtack_n), .reg_rd_o(rd), .reg_wr_o(wr), .reg_wdata_o(wdata_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // independent view of the map from the requirement text
    function automatic bit m_readable(input int off);
        return (off <= 'h0E) || off == 'h16 || off == 'h18 || off == 'h1A ||
               (off >= 'h20 && off <= 'h2A);
    endfunction
    function automatic bit m_writable(input int off);
        return off inside {'h00, 'h02, 'h0A, 'h0C, 'h0E, 'h10, 'h1A, 'h20, 'h22, 'h28, 'h2A, 'h2E};
    endfunction
    function automatic bit m_hit(input logic [31:0] a, input logic [5:0] m);
        bit pg;
        if (m == 6'h39 || m == 6'h3D)      pg = (a[23:16] == BASE[7:0]);
        else if (m == 6'h09 || m == 6'h0D) pg = (a[31:16] == BASE);
        else                               pg = 0;
        return pg && (a[15:6] == 0) && (a[5:0] <= 6'h2E);
    endfunction

    // cycle-by-cycle reference model
    int          m_ph = 0;
    int          m_off = 0;
    bit          m_wr = 0;
    logic [15:0] m_wd = '0;
    logic        e_dtack_n = 1, e_oe = 0;
    logic [15:0] e_data = '0, e_wdata = '0;
    logic [NR-1:0] e_rd = '0, e_wr = '0;

    always @(posedge clk) begin
        bit strobe, idle;
        strobe = !as_n && !ds0_n && !ds1_n;
        idle   = ds0_n && ds1_n;
        e_rd = '0; e_wr = '0;
        if (rst) begin
            m_ph = 0; e_dtack_n = 1; e_oe = 0; e_data = '0;
        end else begin
            case (m_ph)
                0: if (strobe) begin
                       if (m_hit(addr, am)) begin
                           m_ph = 1; m_off = int'(addr[5:0]); m_wr = !write_n; m_wd = wdata;
                       end else m_ph = 3;
                   end
                1: if (strobe) begin
                       m_ph = 2; e_dtack_n = 0; e_wdata = m_wd;
                       if (m_wr) begin
                           e_oe = 0; e_data = '0;
                           if (m_writable(m_off)) e_wr[m_off/2] = 1'b1;
                       end else begin
                           e_oe = 1;
                           e_data = m_readable(m_off) ? pat[m_off/2] : 16'h0;
                           if (m_readable(m_off)) e_rd[m_off/2] = 1'b1;
                       end
                   end else m_ph = 0;
                2: if (idle) begin
                       m_ph = 0; e_dtack_n = 1; e_oe = 0; e_data = '0;
                   end
                default: if (idle) m_ph = 0;
            endcase
        end
    end

    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            chk(dtack_n === e_dtack_n, "R5 model dtack", 32'(dtack_n), 32'(e_dtack_n));
            chk(rd === e_rd, "R6 model read strobes", 32'(rd), 32'(e_rd));
            chk(wr === e_wr, "R7 model write strobes", 32'(wr), 32'(e_wr));
            chk(data_o === e_data, "R6 model read data", 32'(data_o), 32'(e_data));
            chk(oe === e_oe, "R6 model output enable", 32'(oe), 32'(e_oe));
            if (e_wr != '0)
                chk(wdata_o === e_wdata, "R7 model write data", 32'(wdata_o), 32'(e_wdata));
        end
    end

    // directed access
    bit          got_ack, got_oe, rel_ok;
    int          ack_cyc, npulse;
    logic [15:0] got_data, wd_seen;
    logic [NR-1:0] rd_acc, wr_acc;

    task automatic access(input logic [31:0] a, input logic [5:0] m, input bit w,
                          input logic [15:0] d, input int hold, input bit one_ds);
        @(negedge clk);
        addr = a; am = m; write_n = !w; wdata = d;
        as_n = 0; ds0_n = 0; ds1_n = one_ds;
        got_ack = 0; ack_cyc = -1; npulse = 0; rd_acc = '0; wr_acc = '0;
        got_data = '0; got_oe = 0; wd_seen = '0; rel_ok = 1;
        for (int c = 1; c <= hold; c++) begin
            @(posedge clk); #5;
            if (!dtack_n && !got_ack) begin
                got_ack = 1; ack_cyc = c; got_data = data_o; got_oe = oe;
            end
            rd_acc |= rd; wr_acc |= wr;
            if ((|rd) || (|wr)) npulse++;
            if (|wr) wd_seen = wdata_o;
        end
        @(negedge clk);
        as_n = 1; ds0_n = 1; ds1_n = 1;
        @(posedge clk); #5;
        rel_ok = (dtack_n === 1'b1);
        @(posedge clk);
    endtask

    localparam logic [31:0] A24B = 32'h00AB0000;
    localparam logic [31:0] A32B = 32'h12AB0000;

    initial begin
        for (int i = 0; i < NR; i++) pat[i] = 16'(16'h5A00 ^ (i * 16'h0107));
        repeat (3) @(posedge clk);
        #5;
        chk(dtack_n === 1'b1, "R11 reset dtack", 32'(dtack_n), 1);
        chk(oe === 1'b0 && rd == '0 && wr == '0 && data_o == '0, "R11 reset outputs",
            {oe, 15'(data_o), 16'(|{rd, wr})}, 0);
        @(negedge clk); rst = 0;

        // R1 / R6 / R5 : the four accepted codes
        access(A24B | 32'h02, 6'h39, 0, 0, 4, 0);
        chk(got_ack && ack_cyc == 2, "R5 dtack two edges after strobe", 32'(ack_cyc), 2);
        chk(got_data == pat[1] && got_oe, "R6 read data offset 0x02", 32'(got_data), 32'(pat[1]));
        chk(rd_acc == NR'(1 << 1) && npulse == 1, "R6 read strobe slot 1", 32'(rd_acc), 32'(1 << 1));
        chk(rel_ok, "R5 dtack released after strobes high", 32'(dtack_n), 1);
        access(A24B | 32'h0E, 6'h3D, 0, 0, 4, 0);
        chk(got_ack && got_data == pat[7], "R1 AM 0x3D read", 32'(got_data), 32'(pat[7]));
        access(A32B | 32'h24, 6'h09, 0, 0, 4, 0);
        chk(got_ack && got_data == pat[18] && rd_acc == NR'(1 << 18), "R8 AM 0x09 read 0x24", 32'(got_data), 32'(pat[18]));
        access(A32B | 32'h2A, 6'h0D, 0, 0, 4, 0);
        chk(got_ack && got_data == pat[21], "R1 AM 0x0D read", 32'(got_data), 32'(pat[21]));
        access(A24B | 32'h02, 6'h29, 0, 0, 4, 0);
        chk(!got_ack && rd_acc == '0, "R1 AM 0x29 ignored", 32'(got_ack), 0);
        access(A24B | 32'h02, 6'h3B, 0, 0, 4, 0);
        chk(!got_ack, "R1 AM 0x3B ignored", 32'(got_ack), 0);

        // R2 page compare
        access(32'h7EAB0004, 6'h39, 0, 0, 4, 0);
        chk(got_ack && got_data == pat[2], "R2 A24 ignores A31..A24", 32'(got_data), 32'(pat[2]));
        access(32'h00AC0004, 6'h39, 0, 0, 4, 0);
        chk(!got_ack, "R2 A24 wrong page", 32'(got_ack), 0);
        access(32'h13AB0004, 6'h09, 0, 0, 4, 0);
        chk(!got_ack, "R2 A32 wrong upper byte", 32'(got_ack), 0);

        // R3 middle bits and out-of-map offsets
        access(A32B | 32'h0104, 6'h09, 0, 0, 4, 0);
        chk(!got_ack, "R3 A8 set", 32'(got_ack), 0);
        access(A32B | 32'h30, 6'h09, 0, 0, 4, 0);
        chk(!got_ack, "R3 offset 0x30", 32'(got_ack), 0);
        access(A32B | 32'h3E, 6'h09, 1, 16'h1234, 4, 0);
        chk(!got_ack && wr_acc == '0, "R3 offset 0x3E write", 32'(got_ack), 0);

        // R4 single data strobe
        access(A24B | 32'h00, 6'h39, 0, 0, 4, 1);
        chk(!got_ack && rd_acc == '0, "R4 one data strobe only", 32'(got_ack), 0);

        // R7 writes
        access(A24B | 32'h28, 6'h39, 1, 16'hBEEF, 4, 0);
        chk(got_ack && wr_acc == NR'(1 << 20) && !got_oe, "R7 write strobe slot 20", 32'(wr_acc), 32'(1 << 20));
        chk(wd_seen == 16'hBEEF, "R7 write data", 32'(wd_seen), 32'h0000BEEF);
        access(A32B | 32'h2E, 6'h0D, 1, 16'h0001, 4, 0);
        chk(got_ack && wr_acc == NR'(1 << 23), "R8 write-only 0x2E strobe", 32'(wr_acc), 32'(1 << 23));
        access(A32B | 32'h10, 6'h09, 1, 16'h00FF, 4, 0);
        chk(got_ack && wr_acc == NR'(1 << 8), "R8 write-only 0x10 strobe", 32'(wr_acc), 32'(1 << 8));

        // R9 acknowledged without effect
        access(A24B | 32'h04, 6'h39, 1, 16'hFFFF, 4, 0);
        chk(got_ack && wr_acc == '0 && rd_acc == '0, "R9 write to read-only", 32'(wr_acc), 0);
        access(A24B | 32'h10, 6'h39, 0, 0, 4, 0);
        chk(got_ack && got_data == 0 && rd_acc == '0, "R9 read of write-only", 32'(got_data), 0);
        access(A24B | 32'h12, 6'h39, 0, 0, 4, 0);
        chk(got_ack && got_data == 0 && rd_acc == '0, "R9 reserved read", 32'(got_data), 0);
        access(A24B | 32'h2C, 6'h39, 1, 16'h5555, 4, 0);
        chk(got_ack && wr_acc == '0, "R9 reserved write", 32'(wr_acc), 0);

        // R8 read-clear slot gets a read strobe
        access(A24B | 32'h16, 6'h39, 0, 0, 4, 0);
        chk(rd_acc == NR'(1 << 11) && got_data == pat[11], "R8 read-clear 0x16", 32'(rd_acc), 32'(1 << 11));

        // R10 long hold gives one strobe
        access(A24B | 32'h1A, 6'h39, 0, 0, 12, 0);
        chk(npulse == 1, "R10 one strobe per assertion", 32'(npulse), 1);

        // R10 back-to-back with a one-cycle gap
        begin
            int acks = 0;
            logic [NR-1:0] wacc = '0;
            bit prev = 1;
            @(negedge clk);
            addr = A24B; am = 6'h39; write_n = 1; as_n = 0; ds0_n = 0; ds1_n = 0;
            repeat (3) @(negedge clk);
            as_n = 1; ds0_n = 1; ds1_n = 1;
            @(negedge clk);
            addr = A24B | 32'h02; write_n = 0; wdata = 16'hC0DE; as_n = 0; ds0_n = 0; ds1_n = 0;
            for (int c = 0; c < 4; c++) begin
                @(posedge clk); #5;
                if (prev && !dtack_n) acks++;
                prev = dtack_n;
                wacc |= wr;
            end
            @(negedge clk);
            as_n = 1; ds0_n = 1; ds1_n = 1;
            repeat (2) @(posedge clk);
            chk(acks == 1 && wacc == NR'(1 << 1), "R10 second access after one-cycle gap", 32'(wacc), 32'(1 << 1));
        end

        repeat (3) @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_err++;
            $display("FAIL R5 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule